// File: doc/BRIEF.md
# DS0 Idle and Robbed-Bit Inserter

This block sits in the transmit path of a T1 framer and rewrites the payload bytes of the 24 DS0 channels as they stream past. Each input byte comes with its channel index and its frame number in the superframe. Each byte can be replaced by an idle code. During the signaling frames, its least significant bit can also carry that channel's robbed-bit signaling value. Framing bits and line coding are handled elsewhere.

Per-channel behaviour is set by two 24-bit masks. The idle mask picks the channels that carry an idle code, and one select input chooses 0x7F or 0xFF as that code. The transparent mask exempts channels from signaling insertion, so voice and clear data channels can share a frame. Idle substitution is done first and signaling insertion second. An idle channel that is not transparent is therefore still bit-robbed. Setting all idle bits with code 0xFF and signaling disabled gives a framed all-ones payload (blue alarm).

Top module: `chan_idle_sig_insert`

## Requirements
- R1: `out_valid` is high exactly one clock after `in_valid` is high, and `data_out` then holds the result for the byte presented in that earlier cycle.
- R2: When bit n of `idle_mask` is set (bit 0 = channel 0), the byte for channel n is replaced by the idle code. Channels whose bit is clear keep their payload.
- R3: `idle_ff_sel` = 0 selects idle code 0x7F, and `idle_ff_sel` = 1 selects 0xFF.
- R4: With `rob_en` = 0, no byte has its LSB altered, in any frame.
- R5: With `rob_en` = 1 and `sf24` = 0 (12-frame superframe, `frame_num` 1..12), frame 6 puts `sig_abcd[0]` (A) into the LSB and frame 12 puts `sig_abcd[1]` (B) into it. Every other frame number, including 13..24, is left unchanged.
- R6: With `rob_en` = 1 and `sf24` = 1 (24-frame superframe, `frame_num` 1..24), frames 6, 12, 18 and 24 put `sig_abcd[0]`, `[1]`, `[2]` and `[3]` (A, B, C, D) into the LSB.
- R7: A channel whose bit is set in `clear_mask` (bit n = channel n) gets no signaling insertion.
- R8: Signaling is applied after idle substitution. A non-transparent idle channel in a signaling frame outputs the idle code's upper 7 bits with the signaling bit as its LSB.
- R9: With all 24 idle bits set, `idle_ff_sel` = 1 and `rob_en` = 0, every channel outputs 0xFF.
- R10: A `chan_idx` of 24 or more passes `data_in` through unchanged.
- R11: While in reset, `out_valid` and `data_out` are 0. A cycle with `in_valid` low leaves `data_out` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte strobe |
| chan_idx | input | 5 | Channel index of the input byte, 0..23 |
| frame_num | input | 5 | Frame number in the superframe, counted from 1 |
| sf24 | input | 1 | 1 = 24-frame superframe, 0 = 12-frame superframe |
| data_in | input | 8 | Payload byte |
| sig_abcd | input | 4 | Signaling bits of this channel; bit 0 = A, bit 3 = D |
| idle_mask | input | 24 | Per-channel idle enables |
| idle_ff_sel | input | 1 | Idle code select: 0 gives 0x7F, 1 gives 0xFF |
| rob_en | input | 1 | Robbed-bit signaling enable |
| clear_mask | input | 24 | Per-channel signaling exemptions |
| out_valid | output | 1 | Output byte strobe |
| data_out | output | 8 | Processed byte |

## Verification
Every result is due exactly one clock after its input is accepted. The strobe and the byte both come from a single register stage. The driver applies each byte on a falling edge, and at the same moment it pushes the expected value, computed from the requirements, into a queue. The monitor reads outputs on each following falling edge and pops one entry whenever `out_valid` is high. A strobe with an empty queue, or entries left in the queue at the end, counts as a failure. Back-to-back streaming, gaps and configuration changes between bytes are all covered by that one-cycle alignment.

// File: rtl/chan_idle_sig_insert.sv
module chan_idle_sig_insert #(
  parameter int NUM_CH = 24,
  parameter int CH_W   = 5,
  parameter int FR_W   = 5,
  parameter int DW     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [CH_W-1:0]   chan_idx,
  input  logic [FR_W-1:0]   frame_num,
  input  logic              sf24,
  input  logic [DW-1:0]     data_in,
  input  logic [3:0]        sig_abcd,
  input  logic [NUM_CH-1:0] idle_mask,
  input  logic              idle_ff_sel,
  input  logic              rob_en,
  input  logic [NUM_CH-1:0] clear_mask,
  output logic              out_valid,
  output logic [DW-1:0]     data_out
);
  localparam logic [DW-1:0] CODE_7F = DW'(8'h7F);
  localparam logic [DW-1:0] CODE_FF = DW'(8'hFF);

  logic          chan_ok, idle_hit, clear_hit, sig_frame, rob_hit;
  logic [1:0]    sig_sel;
  logic [DW-1:0] base, result;

  assign chan_ok   = 32'(chan_idx) < NUM_CH;
  assign idle_hit  = chan_ok && idle_mask[chan_idx];
  assign clear_hit = chan_ok && clear_mask[chan_idx];
  assign base      = idle_hit ? (idle_ff_sel ? CODE_FF : CODE_7F) : data_in;

  always_comb begin
    sig_frame = 1'b1;
    sig_sel   = 2'd0;
    if (frame_num == FR_W'(6))                sig_sel = 2'd0;
    else if (frame_num == FR_W'(12))          sig_sel = 2'd1;
    else if (sf24 && frame_num == FR_W'(18))  sig_sel = 2'd2;
    else if (sf24 && frame_num == FR_W'(24))  sig_sel = 2'd3;
    else                                      sig_frame = 1'b0;
  end

  assign rob_hit = rob_en && chan_ok && !clear_hit && sig_frame;
  assign result  = rob_hit ? {base[DW-1:1], sig_abcd[sig_sel]} : base;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      data_out  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) data_out <= result;
    end
  end
endmodule

// File: rtl/chan_idle_sig_insert_chk.sv
module chan_idle_sig_insert_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [4:0]  chan_idx,
  input logic [4:0]  frame_num,
  input logic        sf24,
  input logic [7:0]  data_in,
  input logic [23:0] idle_mask,
  input logic        idle_ff_sel,
  input logic        rob_en,
  input logic [23:0] clear_mask,
  input logic        out_valid,
  input logic [7:0]  data_out
);
  logic in_rng, is_idle, is_clear, robbing_frame;
  assign in_rng   = chan_idx < 5'd24;
  assign is_idle  = in_rng && idle_mask[chan_idx];
  assign is_clear = in_rng && clear_mask[chan_idx];
  assign robbing_frame = frame_num == 5'd6 || frame_num == 5'd12 ||
                         (sf24 && (frame_num == 5'd18 || frame_num == 5'd24));

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid); // R1
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !out_valid); // R1
  AST_IDLE_UPPER_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && is_idle |=> data_out[7:1] == ($past(idle_ff_sel) ? 7'h7F : 7'h3F)); // R8
  AST_IDLE_CODE_NOROB: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && is_idle && !rob_en |=> data_out == ($past(idle_ff_sel) ? 8'hFF : 8'h7F)); // R3
  AST_ROB_OFF_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !is_idle && !rob_en |=> data_out == $past(data_in)); // R4
  AST_CLEAR_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !is_idle && is_clear |=> data_out == $past(data_in)); // R7
  AST_NONSIG_FRAME_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !is_idle && !robbing_frame |=> data_out == $past(data_in)); // R5
  AST_OUT_OF_RANGE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !in_rng |=> data_out == $past(data_in)); // R10
  AST_HOLD_IDLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(data_out)); // R11
endmodule

bind chan_idle_sig_insert chan_idle_sig_insert_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .chan_idx(chan_idx),
  .frame_num(frame_num), .sf24(sf24), .data_in(data_in),
  .idle_mask(idle_mask), .idle_ff_sel(idle_ff_sel), .rob_en(rob_en),
  .clear_mask(clear_mask), .out_valid(out_valid), .data_out(data_out)
);

// File: tb/chan_idle_sig_insert_test.sv
`timescale 1ns/1ps
module chan_idle_sig_insert_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [4:0]  chan_idx = '0;
  logic [4:0]  frame_num = 5'd1;
  logic        sf24 = 1'b0;
  logic [7:0]  data_in = '0;
  logic [3:0]  sig_abcd = '0;
  logic [23:0] idle_mask = '0;
  logic        idle_ff_sel = 1'b0;
  logic        rob_en = 1'b0;
  logic [23:0] clear_mask = '0;
  logic        out_valid;
  logic [7:0]  data_out;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  typedef struct { logic [7:0] val; string tag; } exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;

  chan_idle_sig_insert uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .chan_idx(chan_idx),
    .frame_num(frame_num), .sf24(sf24), .data_in(data_in), .sig_abcd(sig_abcd),
    .idle_mask(idle_mask), .idle_ff_sel(idle_ff_sel), .rob_en(rob_en),
    .clear_mask(clear_mask), .out_valid(out_valid), .data_out(data_out)
  );

  function automatic logic [7:0] model(int ch, int fr, logic [7:0] d, logic [3:0] s);
    logic [7:0] v;
    int slot;
    if (ch >= 24) return d;
    v = idle_mask[ch] ? (idle_ff_sel ? 8'hFF : 8'h7F) : d;
    slot = -1;
    if (fr == 6) slot = 0;
    else if (fr == 12) slot = 1;
    else if (sf24 && fr == 18) slot = 2;
    else if (sf24 && fr == 24) slot = 3;
    if (rob_en && !clear_mask[ch] && slot >= 0) v[0] = s[slot];
    return v;
  endfunction

  task automatic check(bit ok, string tag, logic [7:0] act, logic [7:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic send(int ch, int fr, logic [7:0] d, logic [3:0] s, string tag);
    exp_t e;
    @(negedge clk);
    chan_idx = 5'(ch); frame_num = 5'(fr); data_in = d; sig_abcd = s;
    in_valid = 1'b1;
    e.val = model(ch, fr, d, s);
    e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic send_burst(int n, string tag);
    exp_t e;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chan_idx = 5'(i % 24); frame_num = 5'(1 + (i / 24) % 24);
      data_in = 8'($urandom); sig_abcd = 4'($urandom);
      in_valid = 1'b1;
      e.val = model(int'(chan_idx), int'(frame_num), data_in, sig_abcd);
      e.tag = tag;
      sb.push_back(e);
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (sb.size() == 0) check(1'b0, "R1 strobe with empty queue", data_out, 8'h00);
      else begin
        exp_t e;
        e = sb.pop_front();
        check(data_out == e.val, e.tag, data_out, e.val);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0 && data_out == 8'h00, "R11 reset state", data_out, 8'h00);
    rst_n = 1'b1;

    idle_mask = 24'h000008;
    send(3, 1, 8'h12, 4'h0, "R2 idle channel 3");
    send(4, 1, 8'h34, 4'h0, "R2 non-idle channel 4");
    send(3, 2, 8'h00, 4'h0, "R3 code 7F");
    idle_ff_sel = 1'b1;
    send(3, 2, 8'h00, 4'h0, "R3 code FF");

    idle_mask = '0;
    rob_en = 1'b0;
    send(5, 6, 8'h00, 4'hF, "R4 rob off frame 6");
    send(5, 12, 8'hFF, 4'h0, "R4 rob off frame 12");

    rob_en = 1'b1; sf24 = 1'b0;
    send(7, 6, 8'hAA, 4'b0001, "R5 frame 6 A");
    send(7, 12, 8'h54, 4'b0010, "R5 frame 12 B");
    send(7, 12, 8'h55, 4'b1101, "R5 frame 12 B zero");
    send(7, 5, 8'h10, 4'hF, "R5 non-signaling frame");
    send(7, 18, 8'h10, 4'hF, "R5 frame 18 ignored in 12-frame mode");

    sf24 = 1'b1;
    send(9, 18, 8'h10, 4'b0100, "R6 frame 18 C");
    send(9, 24, 8'h01, 4'b0111, "R6 frame 24 D");
    send(9, 6, 8'h20, 4'b0001, "R6 frame 6 A");
    send(9, 12, 8'h21, 4'b1101, "R6 frame 12 B");

    clear_mask = 24'h000020;
    send(5, 6, 8'h00, 4'hF, "R7 transparent channel 5");
    send(6, 6, 8'h00, 4'hF, "R7 non-transparent channel 6");

    idle_mask = 24'h000008; idle_ff_sel = 1'b1;
    send(3, 6, 8'h00, 4'h0, "R8 idle FF robbed to FE");
    idle_ff_sel = 1'b0;
    send(3, 12, 8'h00, 4'b0010, "R8 idle 7F LSB set");
    clear_mask = 24'h000008;
    send(3, 6, 8'h00, 4'h0, "R8 idle transparent keeps code");

    idle_mask = 24'hFFFFFF; idle_ff_sel = 1'b1; rob_en = 1'b0; clear_mask = '0;
    for (int c = 0; c < 24; c++) send(c, 6, 8'($urandom), 4'h0, "R9 blue alarm");

    rob_en = 1'b1;
    send(27, 6, 8'h42, 4'hF, "R10 channel 27 passes");
    send(24, 24, 8'h80, 4'hF, "R10 channel 24 passes");

    @(negedge clk);
    check(data_out == 8'h80, "R11 hold with in_valid low", data_out, 8'h80);
    repeat (2) @(negedge clk);
    check(data_out == 8'h80, "R11 hold after gap", data_out, 8'h80);

    idle_mask = 24'h00F0F0; clear_mask = 24'h0F0F00; idle_ff_sel = 1'b0;
    send_burst(600, "R1 streaming 24-frame");
    sf24 = 1'b0; idle_ff_sel = 1'b1;
    send_burst(300, "R1 streaming 12-frame");

    repeat (3) @(negedge clk);
    check(sb.size() == 0, "R1 all results delivered", 8'(sb.size()), 8'h00);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        check(1'b0, "R1 watchdog expired", 8'h00, 8'h00);
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule